// File: doc/BRIEF.md
# Banked Single-Port Word Memory with Per-Bank Power Gating

This block is a synchronous single-port memory of 32-bit words spread over sixteen independent banks. Each bank stores 256 rows of 256 bits, and a row holds eight 32-bit words. A word address is split into a bank index, a row index and a column group. Only the addressed bank sees any peripheral enable: a bank enable, a wordline enable, a sense enable on reads and a write strobe on writes. When no operation is requested, every enable stays low.

The operation for each cycle is decoded by a small controller with three states: `OP_IDLE`, `OP_READ` and `OP_WRITE`. The next-state decode picks `OP_WRITE` whenever write is requested (transition *write-priority*). It picks `OP_READ` when only read is requested (transition *read-only*), and `OP_IDLE` otherwise (transition *no-request*). The registered state records the operation of the previous cycle. Read data from the active bank passes through a sixteen-way select and is captured in an output register on the rising edge that ends the read cycle. Each bank has an activity counter that is brought out on the ports, so the gating can be observed from outside.

Top module: `gated_bank_sram`

## Requirements
- R1: The 15-bit word address is split as bank = addr[14:11], row = addr[10:3] and column group = addr[2:0]. A word written at an address is returned by a later read of that same address.
- R2: In every cycle, at most one bit is set across each of bank_en, wl_en, sense_en and wr_stb. Any bit that is set is the bit of the addressed bank. During a read or a write, bank_en and wl_en carry that bank's bit.
- R3: sense_en is nonzero only in a cycle with a read and no write. wr_stb is nonzero only in a cycle with a write.
- R4: In a cycle with neither rd_en nor wr_en, bank_en, wl_en, sense_en and wr_stb are all zero.
- R5: Read data appears on rdata after the rising clock edge that ends the read cycle, and not before.
- R6: The eight column groups of one row hold independent words. A write to one column group leaves the other seven unchanged.
- R7: Each bank holds its own data. The same row and column in different banks return different stored words.
- R8: When rd_en and wr_en are both high, the write is performed, no sense enable is produced and rdata keeps its previous value.
- R9: rdata holds its value across every cycle without a read.
- R10: act_cnt[16*b +: 16] increments once for each cycle in which bank b is enabled. Counters of banks that are not addressed do not change.
- R11: A synchronous active-high reset clears rdata and all activity counters. It leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request for this cycle |
| wr_en | input | 1 | Write request for this cycle (has priority over read) |
| addr | input | 15 | Word address: bank, row, column group |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| bank_en | output | 16 | One-hot bank enable |
| wl_en | output | 16 | One-hot wordline enable per bank |
| sense_en | output | 16 | One-hot sense enable per bank, reads only |
| wr_stb | output | 16 | One-hot write strobe per bank, writes only |
| act_cnt | output | 256 | Sixteen 16-bit per-bank activity counters, bank b in bits [16*b +: 16] |

## Verification
A read request and a write request can arrive in the same cycle. The controller then has to choose the write, keep the sense enables off and leave the output register alone. The bench first loads rdata with a known word from one bank. It then raises both requests together at an address in a different bank. It judges the outcome in three ways. It checks that the sense vector is zero and the write strobe is one-hot in that cycle. It checks that rdata still holds the earlier word after the edge. It checks that a later read of the collision address returns the newly written word.

// File: rtl/gated_bank_sram_pkg.sv
package gated_bank_sram_pkg;
    localparam int unsigned DEF_BANKS    = 16;
    localparam int unsigned DEF_ROWS     = 256;
    localparam int unsigned DEF_ROW_BITS = 256;
    localparam int unsigned DEF_WORD_W   = 32;
    localparam int unsigned DEF_CNT_W    = 16;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/gba_addr_split.sv
module gba_addr_split #(
    parameter int unsigned BANKS  = 16,
    parameter int unsigned BANK_W = 4,
    parameter int unsigned ROW_W  = 8,
    parameter int unsigned COL_W  = 3,
    localparam int unsigned ADDR_W = BANK_W + ROW_W + COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank_idx,
    output logic [ROW_W-1:0]  row_idx,
    output logic [COL_W-1:0]  col_idx,
    output logic [BANKS-1:0]  bank_sel
);
    assign bank_idx = addr[ADDR_W-1 -: BANK_W];
    assign row_idx  = addr[COL_W +: ROW_W];
    assign col_idx  = addr[COL_W-1:0];

    for (genvar b = 0; b < BANKS; b++) begin : g_sel
        assign bank_sel[b] = (bank_idx == BANK_W'(b));
    end
endmodule

// File: rtl/gba_op_ctrl.sv
module gba_op_ctrl
    import gated_bank_sram_pkg::*;
#(
    parameter int unsigned BANKS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [BANKS-1:0] bank_sel,
    output logic [BANKS-1:0] bank_en,
    output logic [BANKS-1:0] wl_en,
    output logic [BANKS-1:0] sense_en,
    output logic [BANKS-1:0] wr_stb,
    output logic             capture
);
    op_e op_d, op_q;

    always_comb begin
        if (wr_en)      op_d = OP_WRITE;
        else if (rd_en) op_d = OP_READ;
        else            op_d = OP_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) op_q <= OP_IDLE;
        else     op_q <= op_d;
    end

    always_comb begin
        bank_en  = '0;
        wl_en    = '0;
        sense_en = '0;
        wr_stb   = '0;
        capture  = 1'b0;
        unique case (op_d)
            OP_IDLE: ;
            OP_READ: begin
                bank_en  = bank_sel;
                wl_en    = bank_sel;
                sense_en = bank_sel;
                capture  = 1'b1;
            end
            OP_WRITE: begin
                bank_en  = bank_sel;
                wl_en    = bank_sel;
                wr_stb   = bank_sel;
            end
            default: ;
        endcase
    end

    AST_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_en) && $onehot0(sense_en) && $onehot0(wr_stb)); // R2
    AST_SENSE_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (sense_en != '0) |-> (rd_en && !wr_en)); // R3
    AST_STB_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (wr_stb != '0) |-> wr_en); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !wr_en) |-> (bank_en == '0 && wl_en == '0 && sense_en == '0 && wr_stb == '0)); // R4
    AST_COLLIDE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en) |=> (op_q == OP_WRITE)); // R8
endmodule

// File: rtl/gba_bank.sv
module gba_bank #(
    parameter int unsigned ROWS     = 256,
    parameter int unsigned ROW_BITS = 256,
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned CNT_W    = 16,
    localparam int unsigned ROW_W   = $clog2(ROWS),
    localparam int unsigned COL_W   = $clog2(ROW_BITS / WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              sense,
    input  logic              wr,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_word,
    output logic [CNT_W-1:0]  cnt
);
    logic [ROW_BITS-1:0] cells [ROWS];
    logic [ROW_BITS-1:0] row_line;

    assign row_line = cells[row];
    assign rd_word  = sense ? row_line[col*WORD_W +: WORD_W] : '0;

    always_ff @(posedge clk) begin
        if (wr) cells[row][col*WORD_W +: WORD_W] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     cnt <= '0;
        else if (en) cnt <= cnt + 1'b1;
    end

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt)); // R10
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        en |=> (cnt == $past(cnt) + 1'b1)); // R10
    AST_GATED_BANK: assert property (@(posedge clk) disable iff (rst)
        (sense || wr) |-> en); // R2
endmodule

// File: rtl/gated_bank_sram.sv
module gated_bank_sram
    import gated_bank_sram_pkg::*;
#(
    parameter int unsigned BANKS    = DEF_BANKS,
    parameter int unsigned ROWS     = DEF_ROWS,
    parameter int unsigned ROW_BITS = DEF_ROW_BITS,
    parameter int unsigned WORD_W   = DEF_WORD_W,
    parameter int unsigned CNT_W    = DEF_CNT_W,
    localparam int unsigned BANK_W  = $clog2(BANKS),
    localparam int unsigned ROW_W   = $clog2(ROWS),
    localparam int unsigned COL_W   = $clog2(ROW_BITS / WORD_W),
    localparam int unsigned ADDR_W  = BANK_W + ROW_W + COL_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd_en,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [WORD_W-1:0]      wdata,
    output logic [WORD_W-1:0]      rdata,
    output logic [BANKS-1:0]       bank_en,
    output logic [BANKS-1:0]       wl_en,
    output logic [BANKS-1:0]       sense_en,
    output logic [BANKS-1:0]       wr_stb,
    output logic [BANKS*CNT_W-1:0] act_cnt
);
    logic [BANK_W-1:0] bank_idx;
    logic [ROW_W-1:0]  row_idx;
    logic [COL_W-1:0]  col_idx;
    logic [BANKS-1:0]  bank_sel;
    logic              capture;
    logic [WORD_W-1:0] bank_word [BANKS];
    logic [WORD_W-1:0] sel_word;

    gba_addr_split #(
        .BANKS (BANKS),
        .BANK_W(BANK_W),
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_split (
        .addr    (addr),
        .bank_idx(bank_idx),
        .row_idx (row_idx),
        .col_idx (col_idx),
        .bank_sel(bank_sel)
    );

    gba_op_ctrl #(.BANKS(BANKS)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .bank_sel(bank_sel),
        .bank_en (bank_en),
        .wl_en   (wl_en),
        .sense_en(sense_en),
        .wr_stb  (wr_stb),
        .capture (capture)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        gba_bank #(
            .ROWS    (ROWS),
            .ROW_BITS(ROW_BITS),
            .WORD_W  (WORD_W),
            .CNT_W   (CNT_W)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .en     (bank_en[b]),
            .sense  (sense_en[b]),
            .wr     (wr_stb[b]),
            .row    (row_idx),
            .col    (col_idx),
            .wdata  (wdata),
            .rd_word(bank_word[b]),
            .cnt    (act_cnt[b*CNT_W +: CNT_W])
        );
    end

    assign sel_word = bank_word[bank_idx];

    always_ff @(posedge clk) begin
        if (rst)          rdata <= '0;
        else if (capture) rdata <= sel_word;
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)); // R9
    AST_COLLIDE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en) |=> $stable(rdata)); // R8
    AST_EN_ADDRESSED: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en) |-> (bank_en == bank_sel && wl_en == bank_sel)); // R2
endmodule

// File: tb/gated_bank_sram_bench.sv
`timescale 1ns/1ps
module gated_bank_sram_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         rd_en, wr_en;
    logic [14:0]  addr;
    logic [31:0]  wdata;
    logic [31:0]  rdata;
    logic [15:0]  bank_en, wl_en, sense_en, wr_stb;
    logic [255:0] act_cnt;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int exp_cnt [16];

    logic [15:0] s_bank, s_wl, s_sense, s_stb;

    always #2.5 clk = ~clk;

    gated_bank_sram u_gated_bank_sram (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .bank_en(bank_en), .wl_en(wl_en),
        .sense_en(sense_en), .wr_stb(wr_stb), .act_cnt(act_cnt)
    );

    function automatic logic [14:0] mk(int bk, int row, int col);
        return {4'(bk), 8'(row), 3'(col)};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive after falling edge, sample enables mid-cycle, step past rising edge.
    task automatic cyc(logic rd, logic wr, logic [14:0] a, logic [31:0] d);
        @(negedge clk);
        rd_en = rd; wr_en = wr; addr = a; wdata = d;
        #1;
        s_bank = bank_en; s_wl = wl_en; s_sense = sense_en; s_stb = wr_stb;
        if (rd || wr) exp_cnt[a[14:11]]++;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 15'h0, 32'h0);
    endtask

    task automatic check_counts(string req);
        for (int b = 0; b < 16; b++)
            check(req, 64'(act_cnt[b*16 +: 16]), 64'(exp_cnt[b]));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rd_en = 0; wr_en = 0; addr = '0; wdata = '0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        for (int b = 0; b < 16; b++) exp_cnt[b] = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R11 rdata after reset", 64'(rdata), 64'h0);
        check_counts("R11 counters after reset");
        idle();
        check("R4 idle bank_en", 64'(s_bank), 64'h0);
        check("R4 idle wl_en", 64'(s_wl), 64'h0);
        check("R4 idle sense_en", 64'(s_sense), 64'h0);
        check("R4 idle wr_stb", 64'(s_stb), 64'h0);
    endtask

    task automatic t_basic_rw();
        cyc(0, 1, mk(5, 17, 2), 32'hCAFE_0517);
        check("R2 write bank_en", 64'(s_bank), 64'h0020);
        check("R2 write wl_en", 64'(s_wl), 64'h0020);
        check("R3 write no sense", 64'(s_sense), 64'h0);
        check("R3 write strobe", 64'(s_stb), 64'h0020);
        cyc(1, 0, mk(5, 17, 2), 32'h0);
        check("R3 read sense", 64'(s_sense), 64'h0020);
        check("R3 read no strobe", 64'(s_stb), 64'h0);
        check("R1 read back", 64'(rdata), 64'hCAFE_0517);
        cyc(0, 1, mk(15, 255, 7), 32'h1234_FFF7);
        cyc(1, 0, mk(15, 255, 7), 32'h0);
        check("R1 top address read back", 64'(rdata), 64'h1234_FFF7);
        check("R2 top bank sense", 64'(s_sense), 64'h8000);
        idle();
    endtask

    task automatic t_latency();
        cyc(0, 1, mk(2, 40, 1), 32'hAAAA_5555);
        cyc(1, 0, mk(5, 17, 2), 32'h0);
        @(negedge clk);
        rd_en = 1; wr_en = 0; addr = mk(2, 40, 1);
        exp_cnt[2]++;
        #1;
        check("R5 rdata before edge", 64'(rdata), 64'hCAFE_0517);
        @(posedge clk);
        #1;
        check("R5 rdata after edge", 64'(rdata), 64'hAAAA_5555);
        idle();
    endtask

    task automatic t_columns();
        for (int c = 0; c < 8; c++) cyc(0, 1, mk(9, 100, c), 32'h0C00_0000 + 32'(c));
        cyc(0, 1, mk(9, 100, 3), 32'hDEAD_0003);
        for (int c = 0; c < 8; c++) begin
            cyc(1, 0, mk(9, 100, c), 32'h0);
            check("R6 column group word", 64'(rdata),
                  (c == 3) ? 64'hDEAD_0003 : 64'(32'h0C00_0000 + 32'(c)));
        end
        idle();
    endtask

    task automatic t_banks();
        for (int b = 0; b < 16; b++) cyc(0, 1, mk(b, 60, 4), 32'hB000_0000 + 32'(b * 17));
        for (int b = 15; b >= 0; b--) begin
            cyc(1, 0, mk(b, 60, 4), 32'h0);
            check("R7 bank word", 64'(rdata), 64'(32'hB000_0000 + 32'(b * 17)));
            check("R2 read bank_en", 64'(s_bank), 64'(16'h1 << b));
        end
        idle();
    endtask

    task automatic t_collision();
        cyc(1, 0, mk(5, 17, 2), 32'h0);
        check("R8 preload", 64'(rdata), 64'hCAFE_0517);
        cyc(1, 1, mk(11, 3, 6), 32'h7777_B036);
        check("R8 collision no sense", 64'(s_sense), 64'h0);
        check("R8 collision strobe", 64'(s_stb), 64'h0800);
        check("R8 collision rdata held", 64'(rdata), 64'hCAFE_0517);
        cyc(1, 0, mk(11, 3, 6), 32'h0);
        check("R8 collision write landed", 64'(rdata), 64'h7777_B036);
        idle();
    endtask

    task automatic t_hold();
        cyc(1, 0, mk(2, 40, 1), 32'h0);
        cyc(0, 1, mk(2, 40, 1), 32'h0101_0101);
        check("R9 hold across write", 64'(rdata), 64'hAAAA_5555);
        idle();
        idle();
        check("R9 hold across idle", 64'(rdata), 64'hAAAA_5555);
    endtask

    task automatic t_counters();
        check_counts("R10 counters after traffic");
        for (int i = 0; i < 5; i++) cyc(1, 0, mk(7, i, 0), 32'h0);
        idle();
        check_counts("R10 counters after bank 7 reads");
    endtask

    task automatic t_reset_keeps();
        do_reset();
        check("R11 rdata cleared", 64'(rdata), 64'h0);
        check_counts("R11 counters cleared");
        cyc(1, 0, mk(11, 3, 6), 32'h0);
        check("R11 array kept", 64'(rdata), 64'h7777_B036);
        idle();
        check_counts("R11 counters restart");
    endtask

    initial begin
        rst = 1'b1; rd_en = 0; wr_en = 0; addr = '0; wdata = '0;
        for (int b = 0; b < 16; b++) exp_cnt[b] = 0;
        t_reset_state();
        t_basic_rw();
        t_latency();
        t_columns();
        t_banks();
        t_collision();
        t_hold();
        t_counters();
        t_reset_keeps();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule